// File: doc/BRIEF.md
# Counting Level Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines (32 by default) and forwards them to a parent processor. It has two outputs: a normal interrupt and a fast interrupt. For each line it keeps a latched level bit and an enable bit. It also keeps a running total of the lines that are both latched and enabled. That total is adjusted by one, up or down, every time a line's state changes, and is never recounted from scratch.

Software uses a small register window with word offsets. It can read the running total. It can read the index of the lowest-numbered line that is latched and enabled. It enables or disables one line at a time by writing that line's index, not a bit mask. It can also drop every latched level in one write, and that write leaves the enable bits as they are. An access to an offset outside the defined set is flagged on an error output and changes nothing.

Top module: `irq_count_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all latched levels, enables and the pending total are zero, both interrupt outputs are low, and both read offsets return 0.
- R2: A request line is sampled every clock. A low-to-high change on a line whose level bit is clear sets that bit one edge later. The pending total grows by one only if the line is enabled.
- R3: A high-to-low change on a line whose level bit is set clears that bit. The pending total drops by one only if the line is enabled.
- R4: A read at offset 0x00 returns the pending total, zero-extended to the data width.
- R5: A read at offset 0x04 returns the lowest line index whose level and enable bits are both set, or 0 when no line qualifies.
- R6: A write at offset 0x10 takes the line index from the low 5 bits of the write data. If that line is disabled, the write enables it and adds one to the total when its level bit is set. If the line is already enabled, the write has no effect.
- R7: A write at offset 0x0C uses the same low 5 bits as the line index. If that line is enabled, the write disables it and subtracts one from the total when its level bit is set. If the line is already disabled, the write has no effect.
- R8: Any write at offset 0x08 clears every level bit and the total and keeps the enable bits. A line held high through this write stays unlatched until it falls and rises again.
- R9: The normal interrupt output is high exactly when some line is both latched and enabled.
- R10: The fast-enable mask resets to zero and has no write path, so the fast interrupt output stays low.
- R11: During an access to any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10, the error output is high in that cycle and the read data is 0. Such an access changes no state. A read of a command offset returns 0, a write to a read offset is ignored, and neither raises the error.
- R12: When a line changes in the same cycle as a register write, the line update is applied first and the write second. An enable of a line that rises in that cycle therefore counts it once, and a clear-all in that cycle wipes the newly latched level.
- R13: The pending total always equals the number of lines that are both latched and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqIn | input | 32 | Level-sensitive request lines |
| busSel | input | 1 | Register access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset in the 4 KiB window |
| busWdata | input | 32 | Write data (line index in the low bits) |
| busRdata | output | 32 | Read data, same cycle as the access |
| busErr | output | 1 | High during an access to an undefined offset |
| irqOut | output | 1 | Normal interrupt to the parent |
| fiqOut | output | 1 | Fast interrupt to the parent |

## Verification
The bench targets several corner cases, and each one shows up as a wrong pending total or a wrong index read:
- Enabling or disabling a line that is already in that state. A design that ignores the current enable bit drifts the total by one.
- A line still held high across a clear-all. A level-latching design that re-latches from the raw input brings that line back at once, where it should wait for a fresh rise.
- A line rise in the same cycle as an enable or clear-all write. A design with the wrong ordering double-counts the line or keeps a level that should be gone.
- Unaligned and out-of-map offsets, plus a write value with high bits set. A design that checks too few address bits, or uses the whole write word as the index, corrupts the enables.

// File: rtl/irq_count_pkg.sv
package irq_count_pkg;

  // Word offsets inside the register window
  localparam int OFS_COUNT   = 'h00;
  localparam int OFS_INDEX   = 'h04;
  localparam int OFS_CLRALL  = 'h08;
  localparam int OFS_LINEOFF = 'h0C;
  localparam int OFS_LINEON  = 'h10;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic rdCount;
    logic rdIndex;
    logic clrAll;
    logic lineOff;
    logic lineOn;
  } ctlStrobes_t;

endpackage

// File: rtl/irq_count_ctl.sv
module irq_count_ctl
  import irq_count_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStrobes_t       strobes,
  output logic [IDX_W-1:0]  lineIdx,
  output logic              busErr
);

  logic unusedHi;
  assign unusedHi = ^busWdata[DATA_W-1:IDX_W];

  assign lineIdx = busWdata[IDX_W-1:0];

  always_comb begin
    strobes = '0;
    busErr  = 1'b0;
    if (busSel) begin
      case (busAddr)
        ADDR_W'(OFS_COUNT):   strobes.rdCount = !busWr;
        ADDR_W'(OFS_INDEX):   strobes.rdIndex = !busWr;
        ADDR_W'(OFS_CLRALL):  strobes.clrAll  = busWr;
        ADDR_W'(OFS_LINEOFF): strobes.lineOff = busWr;
        ADDR_W'(OFS_LINEON):  strobes.lineOn  = busWr;
        default:              busErr = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/irq_count_dp.sv
module irq_count_dp
  import irq_count_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] reqIn,
  input  ctlStrobes_t          strobes,
  input  logic [IDX_W-1:0]     lineIdx,
  output logic [NUM_LINES-1:0] levelQ,
  output logic [NUM_LINES-1:0] enableQ,
  output logic [CNT_W-1:0]     pendCount,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic                 fiqOut
);

  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] fastQ;
  logic [NUM_LINES-1:0] setNew, clrNew, lvlMid, lvlNext, enNext, pendMask;
  logic [CNT_W-1:0]     cntMid, cntNext;
  logic [IDX_W-1:0]     firstIdx;
  logic                 idxOk;

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_LINES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_LINES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  // Per-line change detection against the previous sample
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    assign setNew[g] = reqIn[g] & ~prevQ[g] & ~levelQ[g];
    assign clrNew[g] = ~reqIn[g] & prevQ[g] & levelQ[g];
  end

  assign idxOk = 32'(lineIdx) < NUM_LINES;

  always_comb begin
    // line updates first
    lvlMid = (levelQ | setNew) & ~clrNew;
    cntMid = pendCount + popCount(setNew & enableQ) - popCount(clrNew & enableQ);
    // then the register write
    lvlNext = lvlMid;
    enNext  = enableQ;
    cntNext = cntMid;
    if (strobes.clrAll) begin
      lvlNext = '0;
      cntNext = '0;
    end else if (strobes.lineOn && idxOk && !enableQ[lineIdx]) begin
      enNext[lineIdx] = 1'b1;
      if (lvlMid[lineIdx]) cntNext = cntMid + 1'b1;
    end else if (strobes.lineOff && idxOk && enableQ[lineIdx]) begin
      enNext[lineIdx] = 1'b0;
      if (lvlMid[lineIdx]) cntNext = cntMid - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ     <= '0;
      levelQ    <= '0;
      enableQ   <= '0;
      pendCount <= '0;
      fastQ     <= '0;
    end else begin
      prevQ     <= reqIn;
      levelQ    <= lvlNext;
      enableQ   <= enNext;
      pendCount <= cntNext;
    end
  end

  assign pendMask = levelQ & enableQ;

  always_comb begin
    firstIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (pendMask[i]) firstIdx = IDX_W'(i);
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdCount)      rdData = DATA_W'(pendCount);
    else if (strobes.rdIndex) rdData = DATA_W'(firstIdx);
  end

  assign irqOut = |pendMask;
  assign fiqOut = |(levelQ & fastQ);

endmodule

// File: rtl/irq_count_ctrl.sv
module irq_count_ctrl
  import irq_count_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busErr,
  output logic                 irqOut,
  output logic                 fiqOut
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int CNT_W = $clog2(NUM_LINES + 1);

  ctlStrobes_t          strobes;
  logic [IDX_W-1:0]     lineIdx;
  logic [NUM_LINES-1:0] levelQ, enableQ;
  logic [CNT_W-1:0]     pendCount;

  irq_count_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .strobes(strobes), .lineIdx(lineIdx), .busErr(busErr)
  );

  irq_count_dp #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .reqIn(reqIn), .strobes(strobes), .lineIdx(lineIdx),
    .levelQ(levelQ), .enableQ(enableQ), .pendCount(pendCount),
    .rdData(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );

endmodule

// File: rtl/irq_count_chk.sv
module irq_count_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int CNT_W     = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busSel,
  input logic                 busWr,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busRdata,
  input logic                 busErr,
  input logic                 irqOut,
  input logic                 fiqOut,
  input logic [NUM_LINES-1:0] levelQ,
  input logic [NUM_LINES-1:0] enableQ,
  input logic [CNT_W-1:0]     pendCount
);

  logic                 clrWr, idxRd;
  logic [IDX_W-1:0]     rdIdx;
  logic [NUM_LINES-1:0] belowMask;

  assign clrWr     = busSel && busWr && (busAddr == ADDR_W'('h08));
  assign idxRd     = busSel && !busWr && (busAddr == ADDR_W'('h04));
  assign rdIdx     = busRdata[IDX_W-1:0];
  assign belowMask = (NUM_LINES'(1) << rdIdx) - NUM_LINES'(1);

  // R13: incremental total matches the qualifying lines
  assert_count_consistent_R13: assert property (@(posedge clk) disable iff (rst)
    32'(pendCount) == $countones(levelQ & enableQ));

  // R9: normal interrupt tracks a nonzero total
  assert_irq_follows_count_R9: assert property (@(posedge clk) disable iff (rst)
    irqOut == (pendCount != '0));

  // R10: fast interrupt never rises
  assert_fiq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !fiqOut);

  // R11: an error access leaves the enable mask alone
  assert_err_no_effect_R11: assert property (@(posedge clk) disable iff (rst)
    busErr |=> $stable(enableQ));

  // R8: clear-all empties levels and total
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    clrWr |=> (levelQ == '0) && (pendCount == '0));

  // R8: clear-all keeps enables
  assert_clear_keeps_en_R8: assert property (@(posedge clk) disable iff (rst)
    clrWr |=> $stable(enableQ));

  // R5: index read names the lowest qualifying line
  assert_index_lowest_R5: assert property (@(posedge clk) disable iff (rst)
    (idxRd && (|(levelQ & enableQ))) |->
      (levelQ[rdIdx] && enableQ[rdIdx] && ((levelQ & enableQ & belowMask) == '0)));

endmodule

bind irq_count_ctrl irq_count_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busRdata(busRdata), .busErr(busErr), .irqOut(irqOut), .fiqOut(fiqOut),
  .levelQ(levelQ), .enableQ(enableQ), .pendCount(pendCount)
);

// File: tb/sim_irq_count_ctrl.sv
module sim_irq_count_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] reqIn = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr, irqOut, fiqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mLvl, mEn, mPrev, curReq;

  always #5 clk = ~clk;

  irq_count_ctrl u0 (
    .clk(clk), .rst(rst), .reqIn(reqIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic int popc(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit known(input logic [11:0] a);
    return a == 12'h00 || a == 12'h04 || a == 12'h08 || a == 12'h0C || a == 12'h10;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, check combinational outputs, update model, step.
  task automatic cycle(input logic [31:0] req, input bit sel, input bit wr,
                       input logic [11:0] addr, input logic [31:0] data, input string tag);
    logic [31:0] pend, expRd, rise, fall;
    reqIn = req; busSel = sel; busWr = wr; busAddr = addr; busWdata = data;
    #1;
    pend = mLvl & mEn;
    chk("R9", 32'(irqOut), 32'(|pend));
    chk("R10", 32'(fiqOut), 32'd0);
    chk("R11", 32'(busErr), 32'(sel && !known(addr)));
    if (sel && !wr) begin
      expRd = 0;
      if (addr == 12'h00) expRd = popc(pend);
      else if (addr == 12'h04) expRd = lowest(pend);
      chk(tag, busRdata, expRd);
    end
    // model: lines first, then write
    rise = req & ~mPrev;
    fall = ~req & mPrev;
    mLvl = (mLvl | rise) & ~fall;
    mPrev = req;
    if (sel && wr) begin
      if (addr == 12'h08) mLvl = '0;
      else if (addr == 12'h10) mEn[data[4:0]] = 1'b1;
      else if (addr == 12'h0C) mEn[data[4:0]] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(); cycle(curReq, 0, 0, 12'h0, 0, ""); endtask
  task automatic rd(input logic [11:0] a, input string tag); cycle(curReq, 1, 0, a, 0, tag); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); cycle(curReq, 1, 1, a, d, "R11"); endtask
  task automatic setLine(input int n, input bit v);
    curReq[n] = v;
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mLvl = '0; mEn = '0; mPrev = '0; curReq = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", 32'(irqOut), 0);
    chk("R1", 32'(fiqOut), 0);
    rd(12'h00, "R1");
    rd(12'h04, "R1");

    // R6 / R2: enable line 5, raise it, raise disabled line 9
    wr(12'h10, 32'd5);
    setLine(5, 1);
    rd(12'h00, "R2");
    setLine(9, 1);
    rd(12'h00, "R2");
    // R6: enable 9 with level set; re-enable 5 has no effect; high bits dropped
    wr(12'h10, 32'd9);
    rd(12'h00, "R6");
    wr(12'h10, 32'd5);
    rd(12'h00, "R6");
    wr(12'h10, 32'hE3);   // line 3
    rd(12'h00, "R6");
    rd(12'h04, "R5");
    // R3: drop line 5
    setLine(5, 0);
    rd(12'h00, "R3");
    rd(12'h04, "R5");
    // R7: disable 9 twice
    wr(12'h0C, 32'd9);
    rd(12'h00, "R7");
    wr(12'h0C, 32'd9);
    rd(12'h00, "R7");
    // R8: re-enable 9, clear-all with line held high
    wr(12'h10, 32'd9);
    rd(12'h00, "R8");
    wr(12'h08, 32'd0);
    rd(12'h00, "R8");
    idle(); idle();
    rd(12'h00, "R8");
    setLine(9, 0);
    setLine(9, 1);
    rd(12'h00, "R8");
    // R11: undefined offsets and direction mismatch
    rd(12'h14, "R11");
    wr(12'h02C, 32'd9);
    wr(12'h00A, 32'd0);
    wr(12'h00E, 32'd9);
    rd(12'h00, "R11");
    rd(12'h08, "R11");
    wr(12'h00, 32'd9);
    rd(12'h00, "R11");
    // R12: rise and enable in the same cycle
    curReq[7] = 1'b1;
    wr(12'h10, 32'd7);
    rd(12'h00, "R12");
    // R12: rise and clear-all in the same cycle
    wr(12'h10, 32'd12);
    curReq[12] = 1'b1;
    wr(12'h08, 32'd0);
    rd(12'h00, "R12");
    rd(12'h04, "R12");

    // Random phase (R4, R5 and the rest through the model)
    for (int k = 0; k < 4000; k++) begin
      int r;
      if ($urandom % 3 == 0) curReq[$urandom % 32] ^= 1'b1;
      r = $urandom % 10;
      case (r)
        0, 1, 2: rd(12'h00, "R4");
        3, 4:    rd(12'h04, "R5");
        5, 6:    wr(12'h10, $urandom);
        7:       wr(12'h0C, $urandom);
        8:       if ($urandom % 8 == 0) wr(12'h08, 0); else idle();
        default: cycle(curReq, 1, 1'($urandom), 12'($urandom), $urandom, "R11");
      endcase
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule